// File: doc/BRIEF.md
# Single-Cycle 16-bit Accumulator Processor Core

This block is a small processor core that completes one instruction per clock. Each cycle it takes an instruction word from instruction memory and a data word from data memory. It drives a data address, a write-enable and write data toward data memory, and a program counter toward instruction memory. Its state is an address/immediate register (A), a data register (D) and the program counter.

There are two instruction kinds. An immediate word loads itself into A. A compute word drives an embedded six-control ALU whose x operand is D and whose y operand is A or the memory word. The compute word can store the ALU result into any mix of A, D and memory. It can also branch to the address held in A, based on the sign and zero state of the result. For an immediate word the ALU is forced to pass A through unchanged, so the write-data output always carries the ALU result.

The chip reset input is active low and asserts asynchronously. Inside the block it is released through a two-stage synchroniser, so the first state update happens on the third rising edge after the reset input goes high.

Top module: `acc_core`

## Requirements
- R1: When bit 15 of the instruction is 0 (immediate kind), A loads the whole 16-bit instruction word at the clock edge.
- R2: For a compute word (bit 15 = 1), bits 11..6 are, from bit 11 down: clear-x, invert-x, clear-y, invert-y, function, invert-result. The ALU takes x = D and optionally clears and then inverts it, and treats y the same way. It adds x and y when function = 1 and ANDs them when function = 0, then optionally inverts the result.
- R3: In a compute word, bit 12 selects the y operand: 1 selects the memory read word and 0 selects A.
- R4: The memory write enable is high only for a compute word with bit 3 set. The write data is always the ALU result, and the data address is always the low 15 bits of A.
- R5: D loads the ALU result only for a compute word with bit 4 set. Otherwise D holds.
- R6: For a compute word, A loads the ALU result when bit 5 is set and holds when it is clear.
- R7: For a compute word, bits 2, 1 and 0 request a branch when the result is negative (bit 15 set), zero, or strictly positive respectively. The branch is taken when any requested condition holds.
- R8: A taken branch loads the program counter with the value A held before the current edge, even when the same word also writes A.
- R9: An immediate word never writes memory, never changes D and never branches, whatever its low bits are.
- R10: With no branch, the program counter increases by one per cycle and wraps from 0xFFFF to 0x0000.
- R11: While reset is asserted, the program counter, A and D are 0. Asserting reset clears them without waiting for a clock edge. After release they stay 0 through two rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low reset, asynchronous assertion |
| instr_i | input | 16 | Instruction word fetched at the current program counter |
| mem_rdata_i | input | 16 | Data memory word at the current data address |
| mem_we_o | output | 1 | Data memory write enable |
| mem_wdata_o | output | 16 | Data memory write word (ALU result) |
| mem_addr_o | output | 15 | Data memory address (low bits of A) |
| pc_o | output | 16 | Program counter, address of the next instruction |

## Verification
The hardest case to reach from the ports is a compute word that both overwrites A and branches. It shows whether the branch target is the old A or the new one. The bench loads a known A, issues "A = A + 1" with all three condition bits set, and checks that the counter lands on the old value while the address output shows the new one. The program-counter wrap is reached the same way: the ALU constant -1 is written to A and an unconditional branch is taken, because an immediate word cannot carry a value above 0x7FFF. The bench then checks that the next edge gives 0x0000.

// File: rtl/acc_pkg.sv
package acc_pkg;

  // Instruction field positions (encoding is fixed at 16 bits)
  localparam int KIND_BIT  = 15;
  localparam int YSEL_BIT  = 12;
  localparam int OP_LSB    = 6;
  localparam int OP_W      = 6;
  localparam int DST_A_BIT = 5;
  localparam int DST_D_BIT = 4;
  localparam int DST_M_BIT = 3;
  localparam int COND_W    = 3;

  // ALU control word, MSB first matches bits 11..6
  typedef struct packed {
    logic clr_x;
    logic inv_x;
    logic clr_y;
    logic inv_y;
    logic add;
    logic inv_out;
  } alu_op_t;

  // Forced control for the immediate kind: x becomes all ones, AND passes y
  localparam alu_op_t OP_PASS_Y = '{clr_x: 1'b1, inv_x: 1'b1, default: 1'b0};

  typedef struct packed {
    logic             compute;
    logic             y_is_mem;
    alu_op_t          op;
    logic             load_a;
    logic             a_from_instr;
    logic             load_d;
    logic             mem_we;
    logic [COND_W-1:0] cond;   // [2]=negative, [1]=zero, [0]=positive
  } decode_t;

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] instr_i,
  output decode_t           dec_o
);

  // Bits 14..13 carry no meaning in either kind
  logic unused_pad;
  assign unused_pad = ^instr_i[KIND_BIT-1:YSEL_BIT+1];

  always_comb begin
    dec_o.compute = instr_i[KIND_BIT];
    if (instr_i[KIND_BIT]) begin
      dec_o.y_is_mem     = instr_i[YSEL_BIT];
      dec_o.op           = alu_op_t'(instr_i[OP_LSB +: OP_W]);
      dec_o.load_a       = instr_i[DST_A_BIT];
      dec_o.a_from_instr = 1'b0;
      dec_o.load_d       = instr_i[DST_D_BIT];
      dec_o.mem_we       = instr_i[DST_M_BIT];
      dec_o.cond         = instr_i[COND_W-1:0];
    end else begin
      dec_o.y_is_mem     = 1'b0;
      dec_o.op           = OP_PASS_Y;
      dec_o.load_a       = 1'b1;
      dec_o.a_from_instr = 1'b1;
      dec_o.load_d       = 1'b0;
      dec_o.mem_we       = 1'b0;
      dec_o.cond         = '0;
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  alu_op_t           op_i,
  output logic [DATA_W-1:0] res_o,
  output logic              zero_o,
  output logic              neg_o
);

  localparam int NOPS = 2;

  logic [DATA_W-1:0] raw  [NOPS];
  logic [NOPS-1:0]   clr;
  logic [NOPS-1:0]   inv;
  logic [DATA_W-1:0] cond [NOPS];
  logic [DATA_W-1:0] comb_r;

  assign raw[0] = x_i;
  assign raw[1] = y_i;
  assign clr    = {op_i.clr_y, op_i.clr_x};
  assign inv    = {op_i.inv_y, op_i.inv_x};

  // Same conditioning stage for both operands
  for (genvar g = 0; g < NOPS; g++) begin : g_pre
    logic [DATA_W-1:0] cleared;
    always_comb begin
      cleared = clr[g] ? '0 : raw[g];
      cond[g] = inv[g] ? ~cleared : cleared;
    end
  end

  always_comb begin
    comb_r = op_i.add ? (cond[0] + cond[1]) : (cond[0] & cond[1]);
    res_o  = op_i.inv_out ? ~comb_r : comb_r;
    zero_o = (res_o == '0);
    neg_o  = res_o[DATA_W-1];
  end

endmodule

// File: rtl/acc_regs.sv
module acc_regs #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_a_i,
  input  logic              a_from_instr_i,
  input  logic              load_d_i,
  input  logic [DATA_W-1:0] instr_i,
  input  logic [DATA_W-1:0] alu_res_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] d_o
);

  logic [DATA_W-1:0] a_q, a_d;
  logic [DATA_W-1:0] d_q, d_d;

  always_comb begin
    a_d = a_from_instr_i ? instr_i : alu_res_i;
    d_d = alu_res_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
    end else if (load_a_i) begin
      a_q <= a_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q <= '0;
    end else if (load_d_i) begin
      d_q <= d_d;
    end
  end

  assign a_o = a_q;
  assign d_o = d_q;

  assert_d_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_d_i |=> d_q == $past(d_q));

  assert_d_take_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_d_i |=> d_q == $past(alu_res_i));

  assert_a_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_a_i |=> a_q == $past(a_q));

endmodule

// File: rtl/acc_pc.sv
module acc_pc #(
  parameter int PC_W   = 16,
  parameter int COND_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [COND_W-1:0] cond_i,
  input  logic              zero_i,
  input  logic              neg_i,
  input  logic [PC_W-1:0]   target_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              take_o
);

  logic [PC_W-1:0] pc_q, pc_d;
  logic            pos;

  always_comb begin
    pos    = !zero_i && !neg_i;
    take_o = (cond_i[2] && neg_i) || (cond_i[1] && zero_i) || (cond_i[0] && pos);
    pc_d   = take_o ? target_i : pc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  assign pc_o = pc_q;

  assert_jump_target_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> pc_q == $past(target_i));

  assert_pc_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |=> pc_q == PC_W'($past(pc_q) + 1'b1));

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] instr_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DATA_W-2:0] mem_addr_o,
  output logic [DATA_W-1:0] pc_o
);

  localparam int ADDR_W = DATA_W - 1;

  logic              core_rst_n;
  decode_t           dec;
  logic [DATA_W-1:0] a_q, d_q;
  logic [DATA_W-1:0] alu_y, alu_res;
  logic              alu_zero, alu_neg;
  logic              take;

  acc_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (core_rst_n)
  );

  acc_decode #(.DATA_W(DATA_W)) u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  assign alu_y = dec.y_is_mem ? mem_rdata_i : a_q;

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .x_i    (d_q),
    .y_i    (alu_y),
    .op_i   (dec.op),
    .res_o  (alu_res),
    .zero_o (alu_zero),
    .neg_o  (alu_neg)
  );

  acc_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i          (clk_i),
    .rst_ni         (core_rst_n),
    .load_a_i       (dec.load_a),
    .a_from_instr_i (dec.a_from_instr),
    .load_d_i       (dec.load_d),
    .instr_i        (instr_i),
    .alu_res_i      (alu_res),
    .a_o            (a_q),
    .d_o            (d_q)
  );

  acc_pc #(.PC_W(DATA_W), .COND_W(COND_W)) u_pc (
    .clk_i    (clk_i),
    .rst_ni   (core_rst_n),
    .cond_i   (dec.cond),
    .zero_i   (alu_zero),
    .neg_i    (alu_neg),
    .target_i (a_q),
    .pc_o     (pc_o),
    .take_o   (take)
  );

  assign mem_we_o    = dec.mem_we;
  assign mem_wdata_o = alu_res;
  assign mem_addr_o  = a_q[ADDR_W-1:0];

  assert_imm_load_R1: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    !instr_i[KIND_BIT] |=> a_q == $past(instr_i));

  assert_imm_pass_R1: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    !instr_i[KIND_BIT] |-> mem_wdata_o == a_q);

  assert_we_kind_R4: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    mem_we_o |-> instr_i[KIND_BIT] && instr_i[DST_M_BIT]);

  assert_imm_d_R9: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    !instr_i[KIND_BIT] |=> d_q == $past(d_q));

  assert_imm_nojump_R9: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    !instr_i[KIND_BIT] |-> !take);

endmodule

// File: tb/tb_acc_core.sv
`timescale 1ns/1ps
module tb_acc_core;

  localparam logic [5:0] OP_ZERO  = 6'b101010;
  localparam logic [5:0] OP_ONE   = 6'b111111;
  localparam logic [5:0] OP_M1    = 6'b111010;
  localparam logic [5:0] OP_D     = 6'b001100;
  localparam logic [5:0] OP_A     = 6'b110000;
  localparam logic [5:0] OP_APL1  = 6'b110111;
  localparam logic [5:0] OP_DPA   = 6'b000010;
  localparam logic [2:0] DA = 3'b100, DD = 3'b010, DM = 3'b001;

  logic        clk, rst_n;
  logic [15:0] instr, rdata, wdata, pc;
  logic        we;
  logic [14:0] addr;
  logic [15:0] ram [16];
  int checks = 0, fails = 0;
  logic        pre_we;
  logic [15:0] pre_wdata, pre_pc;
  logic [14:0] pre_addr;

  acc_core dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .mem_rdata_i(rdata),
    .mem_we_o(we), .mem_wdata_o(wdata), .mem_addr_o(addr), .pc_o(pc)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign rdata = ram[addr[3:0]];
  always @(posedge clk) if (we) ram[addr[3:0]] <= wdata;

  function automatic logic [15:0] cw(input logic ym, input logic [5:0] op,
                                     input logic [2:0] dst, input logic [2:0] j);
    return {3'b111, ym, op, dst, j};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // Drive one word, capture pre-edge outputs, return just after the edge
  task automatic step(input logic [15:0] w);
    @(negedge clk);
    instr = w;
    #1;
    pre_we = we; pre_wdata = wdata; pre_pc = pc; pre_addr = addr;
    @(posedge clk);
    #1;
  endtask

  task automatic peek(input logic ym, input logic [5:0] op, output logic [15:0] v);
    step(cw(ym, op, 3'b000, 3'b000));
    v = pre_wdata;
  endtask

  task automatic set_a(input logic [15:0] v);
    step({1'b0, v[14:0]});
  endtask

  task automatic set_d(input logic [15:0] v);
    set_a(v);
    step(cw(1'b0, OP_A, DD, 3'b000));
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); #1;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    instr = 16'h0000; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 pc in reset", pc, 16'h0000);
    chk("R11 addr in reset", {1'b0, addr}, 16'h0000);
    release_reset();
    chk("R11 pc held two edges", pc, 16'h0000);
    set_d(16'h1357);
    set_a(16'h0246);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 async pc clear", pc, 16'h0000);
    chk("R11 async A clear", {1'b0, addr}, 16'h0000);
    release_reset();
    peek(1'b0, OP_D, v);
    chk("R11 D cleared", v, 16'h0000);
  endtask

  task automatic t_imm();
    logic [15:0] v;
    set_a(16'h1234);
    chk("R1 imm load", {1'b0, addr}, 16'h1234);
    set_a(16'h7FFF);
    peek(1'b0, OP_A, v);
    chk("R1 imm full word", v, 16'h7FFF);
  endtask

  task automatic t_alu();
    logic [5:0]  ops [13];
    logic [15:0] exps [13];
    logic [15:0] v;
    ops  = '{6'b000010, 6'b010011, 6'b000111, 6'b000000, 6'b010101, 6'b001101,
             6'b001111, 6'b011111, 6'b001110, OP_ZERO, OP_ONE, OP_M1, OP_APL1};
    exps = '{16'h100E, 16'h0E10, 16'hF1F0, 16'h000F, 16'h0FFF, 16'hF0F0,
             16'hF0F1, 16'h0F10, 16'h0F0E, 16'h0000, 16'h0001, 16'hFFFF, 16'h0100};
    set_d(16'h0F0F);
    set_a(16'h00FF);
    for (int i = 0; i < 13; i++) begin
      peek(1'b0, ops[i], v);
      chk($sformatf("R2 alu op %b", ops[i]), v, exps[i]);
    end
  endtask

  task automatic t_ysel();
    logic [15:0] v;
    ram[5] = 16'hBEEF;
    set_a(16'h0005);
    peek(1'b1, OP_A, v);
    chk("R3 y=memory", v, 16'hBEEF);
    peek(1'b0, OP_A, v);
    chk("R3 y=A", v, 16'h0005);
    peek(1'b1, OP_DPA, v);
    chk("R3 D+memory", v, 16'hCDFE);
  endtask

  task automatic t_mem();
    set_a(16'h0009);
    step(cw(1'b0, OP_D, DM, 3'b000));
    chk("R4 we on store", {15'b0, pre_we}, 16'h0001);
    chk("R4 wdata", pre_wdata, 16'h0F0F);
    chk("R4 addr", {1'b0, pre_addr}, 16'h0009);
    chk("R4 ram written", ram[9], 16'h0F0F);
    step(cw(1'b0, OP_D, 3'b000, 3'b000));
    chk("R4 we low without bit3", {15'b0, pre_we}, 16'h0000);
    step(cw(1'b0, OP_M1, DA, 3'b000));
    chk("R4 addr low 15 bits", {1'b0, addr}, 16'h7FFF);
  endtask

  task automatic t_dest();
    logic [15:0] v;
    set_d(16'h0011);
    set_a(16'h0022);
    step(cw(1'b0, OP_ONE, 3'b000, 3'b000));
    peek(1'b0, OP_D, v);
    chk("R5 D holds", v, 16'h0011);
    chk("R6 A holds", {1'b0, addr}, 16'h0022);
    step(cw(1'b0, OP_DPA, DD, 3'b000));
    peek(1'b0, OP_D, v);
    chk("R5 D loads", v, 16'h0033);
    chk("R6 A unchanged by D dest", {1'b0, addr}, 16'h0022);
    step(cw(1'b0, OP_DPA, DA, 3'b000));
    chk("R6 A loads", {1'b0, addr}, 16'h0055);
    peek(1'b0, OP_D, v);
    chk("R5 D unchanged by A dest", v, 16'h0033);
    step(cw(1'b0, OP_DPA, DA | DD, 3'b000));
    peek(1'b0, OP_D, v);
    chk("R5 D both dest", v, 16'h0088);
    chk("R6 A both dest", {1'b0, addr}, 16'h0088);
  endtask

  task automatic t_jump();
    logic [5:0] vops [3];
    logic       negf, zf, posf, tk;
    vops = '{OP_M1, OP_ZERO, OP_ONE};
    for (int j = 0; j < 8; j++) begin
      for (int k = 0; k < 3; k++) begin
        set_a(16'h0200);
        negf = (k == 0); zf = (k == 1); posf = (k == 2);
        tk = (j[2] && negf) || (j[1] && zf) || (j[0] && posf);
        step(cw(1'b0, vops[k], 3'b000, j[2:0]));
        chk($sformatf("R7 cond=%b val=%0d", j[2:0], k), pc,
            tk ? 16'h0200 : 16'(pre_pc + 16'd1));
      end
    end
  endtask

  task automatic t_target();
    set_a(16'h0300);
    step(cw(1'b0, OP_APL1, DA, 3'b111));
    chk("R8 target is old A", pc, 16'h0300);
    chk("R8 A updated", {1'b0, addr}, 16'h0301);
  endtask

  task automatic t_imm_rules();
    logic [15:0] v;
    set_d(16'h4444);
    step(16'h003F);
    chk("R9 imm no write", {15'b0, pre_we}, 16'h0000);
    chk("R9 imm no jump", pc, 16'(pre_pc + 16'd1));
    chk("R9 imm A", {1'b0, addr}, 16'h003F);
    peek(1'b0, OP_D, v);
    chk("R9 imm D kept", v, 16'h4444);
  endtask

  task automatic t_wrap();
    step(cw(1'b0, OP_ZERO, 3'b000, 3'b000));
    chk("R10 increment", pc, 16'(pre_pc + 16'd1));
    step(cw(1'b0, OP_M1, DA, 3'b000));
    step(cw(1'b0, OP_ZERO, 3'b000, 3'b111));
    chk("R10 reach top", pc, 16'hFFFF);
    step(cw(1'b0, OP_ZERO, 3'b000, 3'b000));
    chk("R10 wrap", pc, 16'h0000);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) ram[i] = 16'h0000;
    t_reset();
    t_imm();
    t_alu();
    t_ysel();
    t_mem();
    t_dest();
    t_jump();
    t_target();
    t_imm_rules();
    t_wrap();
    summary();
  end

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

endmodule